// File: doc/BRIEF.md
# ISA slave PROM access decoder

This block sits at the slave edge of an ISA peripheral. It watches the host's I/O and memory read strobes and produces the chip selects for two PROMs on a private byte-wide bus: an address PROM in the low half of the device's I/O window and a boot PROM selected by an external match input. It places the PROM byte, or internal register read data, on the system data bus through a registered output enable. It drives the 16-bit I/O indication for register accesses. It also captures host write data for the internal register file.

The block starts in 8-bit-only mode. It switches permanently to 16-bit capability after it samples the byte-high-enable input going from high to low. A host that never drives that line, such as an 8-bit slot where the line idles high, sees a purely 8-bit device. The I/O window is 32 bytes at a parameterised base. Offsets 0 to 15 hold the address PROM and offsets 16 to 31 hold the internal registers.

Top module: `isa_prom_front`

## Requirements
- R1: After reset `wide_mode` is 0. It becomes 1 after the first clock edge that samples `bhe_n` low when the previous edge sampled it high. It then stays 1 until reset.
- R2: While `wide_mode` is 0, a register read returns one byte on `sd_out[7:0]`, taken from `reg_rdata[15:8]` when `sa[0]`=1 and from `reg_rdata[7:0]` when `sa[0]`=0, with `sd_out[15:8]`=0.
- R3: `aprom_cs_n` is low, combinationally, exactly when `ior_n` is low and `sa` lies in `IO_BASE`..`IO_BASE+15`.
- R4: The edge after an address PROM read is sampled, `sd_out` becomes {8'h00, `prom_d`} and `sd_oe` is 1.
- R5: `io16_n` is low exactly when `sa` lies in `IO_BASE+16`..`IO_BASE+31`, `wide_mode` is 1, and no boot PROM cycle is active. It is therefore high during every address PROM and boot PROM cycle.
- R6: `bprom_cs_n` is low exactly when both `boot_hit_n` and `memr_n` are low. After an edge that samples such a cycle with no I/O read in the window, `sd_out` is {8'h00, `prom_d`}. With `boot_hit_n` high, a memory read selects nothing and enables no output.
- R7: `sd_oe` is 1 only after an edge that sampled an active read: an I/O read in the window, or a boot PROM read. Otherwise it is 0, with `sd_out`=0, so the bus is released one clock after the strobe ends.
- R8: While `iow_n` is low at register offsets, each edge captures `wr_addr`=`sa[3:0]` and write data. A 16-bit write (`wide_mode`=1, `bhe_n`=0, `sa[0]`=0) captures `sd_in` with `wr_be`=2'b11. Otherwise it captures {`sd_in[7:0]`, `sd_in[7:0]`} with `wr_be`=2'b10 for odd `sa` and 2'b01 for even `sa`.
- R9: `wr_strobe` is a one-cycle pulse. It is asserted after the first edge that samples the register write inactive, following one or more edges that sampled it active.
- R10: A register read under the R8 16-bit condition returns the full `reg_rdata` on `sd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sa | input | AW | System address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| bhe_n | input | 1 | Byte-high-enable, active low |
| boot_hit_n | input | 1 | Boot PROM address match, active low |
| sd_in | input | 16 | System data bus, input side |
| prom_d | input | 8 | Private PROM data bus |
| reg_rdata | input | 16 | Internal register read data |
| aprom_cs_n | output | 1 | Address PROM select, active low |
| bprom_cs_n | output | 1 | Boot PROM select, active low |
| io16_n | output | 1 | 16-bit I/O indication, active low |
| sd_out | output | 16 | System data bus, output side |
| sd_oe | output | 1 | System data bus drive enable |
| wide_mode | output | 1 | 16-bit operation enabled |
| wr_data | output | 16 | Captured write data |
| wr_be | output | 2 | Captured byte enables |
| wr_addr | output | 4 | Captured register offset |
| wr_strobe | output | 1 | Write commit pulse |

## Verification
The only hidden state is the 16-bit enable, the previous byte-high-enable sample, and the pending write. A 16-bit enable that is set too early or lost shows at once on `io16_n` during a register access. It shows one edge later as a wrong data width or byte lane on `sd_out` or `wr_data`. A stuck or missed pending write shows on the cycle after the strobe ends, as a missing, doubled or spurious `wr_strobe`. A reference model that updates every clock catches each of these on the first cycle they diverge.

// File: rtl/isa_prom_front.sv
module isa_prom_front #(
  parameter int AW = 10,
  parameter logic [AW-1:0] IO_BASE = 10'h300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sa,
  input  logic          ior_n,
  input  logic          iow_n,
  input  logic          memr_n,
  input  logic          bhe_n,
  input  logic          boot_hit_n,
  input  logic [15:0]   sd_in,
  input  logic [7:0]    prom_d,
  input  logic [15:0]   reg_rdata,
  output logic          aprom_cs_n,
  output logic          bprom_cs_n,
  output logic          io16_n,
  output logic [15:0]   sd_out,
  output logic          sd_oe,
  output logic          wide_mode,
  output logic [15:0]   wr_data,
  output logic [1:0]    wr_be,
  output logic [3:0]    wr_addr,
  output logic          wr_strobe
);
  localparam int WIN_LSB = 5;

  logic win_hit, io_rd, boot_rd, reg_wr, wide_xfer;
  logic bhe_q, wr_pend;
  logic [15:0] rd_word;

  assign win_hit    = sa[AW-1:WIN_LSB] == IO_BASE[AW-1:WIN_LSB];
  assign io_rd      = !ior_n && win_hit;
  assign boot_rd    = !memr_n && !boot_hit_n;
  assign reg_wr     = !iow_n && win_hit && sa[4];
  assign wide_xfer  = wide_mode && !bhe_n && !sa[0];

  assign aprom_cs_n = !(io_rd && !sa[4]);
  assign bprom_cs_n = !boot_rd;
  assign io16_n     = !(win_hit && sa[4] && wide_mode && !boot_rd);

  always_comb begin
    if (io_rd && sa[4])
      rd_word = wide_xfer ? reg_rdata
                          : {8'h00, (sa[0] ? reg_rdata[15:8] : reg_rdata[7:0])};
    else
      rd_word = {8'h00, prom_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bhe_q     <= 1'b1;
      wide_mode <= 1'b0;
      sd_oe     <= 1'b0;
      sd_out    <= '0;
      wr_pend   <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      wr_be     <= '0;
      wr_addr   <= '0;
    end else begin
      bhe_q <= bhe_n;
      if (bhe_q && !bhe_n) wide_mode <= 1'b1;
      sd_oe  <= io_rd || boot_rd;
      sd_out <= (io_rd || boot_rd) ? rd_word : '0;
      wr_pend   <= reg_wr;
      wr_strobe <= wr_pend && !reg_wr;
      if (reg_wr) begin
        wr_addr <= sa[3:0];
        if (wide_xfer) begin
          wr_data <= sd_in;
          wr_be   <= 2'b11;
        end else begin
          wr_data <= {sd_in[7:0], sd_in[7:0]};
          wr_be   <= sa[0] ? 2'b10 : 2'b01;
        end
      end
    end
  end

  assert_wide_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |=> wide_mode);
  assert_narrow_no_io16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> io16_n);
  assert_aprom_needs_ior_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !aprom_cs_n |-> (!ior_n && io16_n));
  assert_bprom_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bprom_cs_n |-> (!memr_n && !boot_hit_n && io16_n));
  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ior_n && memr_n) |=> !sd_oe);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
endmodule

// File: tb/test_isa_prom_front.sv
module test_isa_prom_front;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h300;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] sa = '0;
  logic ior_n = 1, iow_n = 1, memr_n = 1, bhe_n = 1, boot_hit_n = 1;
  logic [15:0] sd_in = '0, reg_rdata = '0;
  logic [7:0] prom_d = '0;
  logic aprom_cs_n, bprom_cs_n, io16_n, sd_oe, wide_mode, wr_strobe;
  logic [15:0] sd_out, wr_data;
  logic [1:0] wr_be;
  logic [3:0] wr_addr;

  int total = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  isa_prom_front #(.AW(AW), .IO_BASE(BASE)) i_isa_prom_front (
    .clk, .rst_n, .sa, .ior_n, .iow_n, .memr_n, .bhe_n, .boot_hit_n,
    .sd_in, .prom_d, .reg_rdata, .aprom_cs_n, .bprom_cs_n, .io16_n,
    .sd_out, .sd_oe, .wide_mode, .wr_data, .wr_be, .wr_addr, .wr_strobe);

  // reference model state
  bit m_wide, m_prev_bhe, m_oe, m_pend, m_stb;
  logic [15:0] m_out, m_wdata;
  logic [1:0] m_be;
  logic [3:0] m_waddr;

  function automatic bit in_win(input logic [AW-1:0] a);
    int off;
    off = int'(a) - int'(BASE);
    return off >= 0 && off < 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wide = 0; m_prev_bhe = 1; m_oe = 0; m_pend = 0; m_stb = 0;
      m_out = 0; m_wdata = 0; m_be = 0; m_waddr = 0;
    end else begin
      bit rd_io, rd_boot, wr_reg, big;
      int off;
      off = int'(sa) - int'(BASE);
      rd_io = !ior_n && in_win(sa);
      rd_boot = !memr_n && !boot_hit_n;
      wr_reg = !iow_n && in_win(sa) && off >= 16;
      big = m_wide && !bhe_n && (off % 2 == 0);
      m_stb = m_pend && !wr_reg;
      m_pend = wr_reg;
      if (wr_reg) begin
        m_waddr = off[3:0];
        if (big) begin m_wdata = sd_in; m_be = 2'b11; end
        else begin
          m_wdata = {2{sd_in[7:0]}};
          m_be = (off % 2 == 1) ? 2'b10 : 2'b01;
        end
      end
      m_oe = rd_io || rd_boot;
      if (rd_io && off >= 16)
        m_out = big ? reg_rdata : (off % 2 == 1 ? {8'h00, reg_rdata[15:8]} : {8'h00, reg_rdata[7:0]});
      else if (rd_io || rd_boot) m_out = {8'h00, prom_d};
      else m_out = 0;
      if (m_prev_bhe && !bhe_n) m_wide = 1;
      m_prev_bhe = bhe_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      int off;
      bit e_acs, e_bcs, e_io16;
      off = int'(sa) - int'(BASE);
      e_acs = !(!ior_n && in_win(sa) && off < 16);
      e_bcs = !(!memr_n && !boot_hit_n);
      e_io16 = !(in_win(sa) && off >= 16 && m_wide && e_bcs);
      chk(wide_mode == m_wide, "R1 wide_mode", 16'(wide_mode), 16'(m_wide));
      chk(aprom_cs_n == e_acs, "R3 aprom_cs_n", 16'(aprom_cs_n), 16'(e_acs));
      chk(bprom_cs_n == e_bcs, "R6 bprom_cs_n", 16'(bprom_cs_n), 16'(e_bcs));
      chk(io16_n == e_io16, "R5 io16_n", 16'(io16_n), 16'(e_io16));
      chk(sd_oe == m_oe, "R7 sd_oe", 16'(sd_oe), 16'(m_oe));
      chk(sd_out == m_out, "R4/R2/R10 sd_out", sd_out, m_out);
      chk(wr_strobe == m_stb, "R9 wr_strobe", 16'(wr_strobe), 16'(m_stb));
      chk({wr_data, wr_be, wr_addr} == {m_wdata, m_be, m_waddr}, "R8 write capture",
          wr_data, m_wdata);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic io_read(input logic [AW-1:0] a, input int len);
    sa = a; ior_n = 0; step(len); ior_n = 1; step(2);
  endtask

  task automatic io_write(input logic [AW-1:0] a, input logic [15:0] d);
    sa = a; sd_in = d; iow_n = 0; step(2); iow_n = 1; step(3);
  endtask

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    chk(wide_mode == 0 && sd_oe == 0, "R1 reset state", 16'(wide_mode), 16'h0);
    prom_d = 8'hA5;
    io_read(BASE + 3, 3);                 // R3 R4 address PROM, 8-bit mode
    sa = BASE + 5; ior_n = 0; step(1);
    chk(aprom_cs_n == 0 && sd_out == 16'h00A5 && io16_n == 1, "R4 prom byte", sd_out, 16'h00A5);
    ior_n = 1; step(1);
    chk(sd_oe == 0, "R7 release", 16'(sd_oe), 16'h0);
    reg_rdata = 16'h1234;
    sa = BASE + 8'h11; ior_n = 0; step(1);
    chk(sd_out == 16'h0012 && io16_n == 1, "R2 odd byte narrow", sd_out, 16'h0012);
    ior_n = 1; step(1);
    io_write(BASE + 8'h13, 16'h77AB);
    chk(wr_data == 16'hABAB && wr_be == 2'b10, "R8 narrow write", wr_data, 16'hABAB);
    bhe_n = 0; step(2);                   // R1 falling edge
    chk(wide_mode == 1, "R1 wide after fall", 16'(wide_mode), 16'h1);
    prom_d = 8'h3C;
    sa = BASE + 1; ior_n = 0; step(1);
    chk(io16_n == 1 && sd_out == 16'h003C, "R5 io16 off for address PROM", 16'(io16_n), 16'h1);
    ior_n = 1; step(1);
    sa = BASE + 8'h12; ior_n = 0; step(1);
    chk(io16_n == 0 && sd_out == 16'h1234, "R10 word read", sd_out, 16'h1234);
    ior_n = 1; step(1);
    io_write(BASE + 8'h14, 16'hBEEF);
    chk(wr_data == 16'hBEEF && wr_be == 2'b11 && wr_addr == 4'h4, "R8 word write", wr_data, 16'hBEEF);
    sa = BASE + 8'h40; memr_n = 0; boot_hit_n = 1; step(2);
    chk(bprom_cs_n == 1 && sd_oe == 0, "R6 match inactive", 16'(bprom_cs_n), 16'h1);
    boot_hit_n = 0; prom_d = 8'h5E; step(2);
    chk(bprom_cs_n == 0 && sd_out == 16'h005E, "R6 boot read", sd_out, 16'h005E);
    memr_n = 1; boot_hit_n = 1; step(1);
    io_read(BASE + 8'h20, 2);             // R7 outside window
    begin
      logic [31:0] lcg = 32'h1;
      for (int i = 0; i < 400; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        sa = BASE + AW'(lcg[20:15]);
        ior_n = lcg[23] | lcg[24];
        iow_n = lcg[25] | lcg[26];
        memr_n = lcg[27];
        boot_hit_n = lcg[28];
        bhe_n = lcg[29];
        sd_in = lcg[15:0];
        prom_d = lcg[31:24];
        reg_rdata = lcg[30:15];
        step(1);
      end
    end
    ior_n = 1; iow_n = 1; memr_n = 1; boot_hit_n = 1;
    step(3);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule